// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Mailbox

This block links two processors, called side A and side B, through two independent register ports that share one clock. Each side sees four outbound data registers, four inbound data registers, a status register and a control register. A word one side writes into outbound slot n appears in inbound slot n of the other side. A per-slot handshake flag tracks each word: it is set when the word is written and cleared when the other side reads it. Each side can also ring four doorbells on the opposite side. Each doorbell raises a pending flag there, and software clears that flag by writing a one to it.

Every side drives three level interrupt lines. Each line is the OR, over the four channels, of a status flag gated by its enable bit. A reset request from software on either side clears the whole mailbox. A busy flag stays visible in status until the clearing is done. Register reads have no wait state. A read of an inbound data register consumes the word in the same cycle.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, status reads 0x00F0_0000 on both sides: every outbound-empty flag is 1, every inbound-full and doorbell-pending flag is 0, and the reset-busy flag is 0. Control reads 0 and all interrupt outputs are low.
- R2: Word address (byte address bits [5:2]) 0..3 selects outbound slot n, 4..7 selects inbound slot n, 8 selects status and 9 selects control. All other words read 0, and writes to them or to inbound slots have no effect. Reading outbound slot n returns the last word written to it.
- R3: Status holds, for channel n, doorbell-pending at bit 31−n, inbound-full at bit 27−n, outbound-empty at bit 23−n, and reset-busy at bit 7. Control holds doorbell-enable at bit 31−n, inbound-enable at bit 27−n, outbound-enable at bit 23−n, ring-request at bit 19−n and reset-request at bit 5.
- R4: A write to outbound slot n clears the writer's outbound-empty n and sets the far side's inbound-full n from the next cycle on. The far side then reads the written word from inbound slot n.
- R5: Reading inbound slot n returns the word, clears inbound-full n and sets the sender's outbound-empty n from the next cycle on. Reading an empty slot changes no flag.
- R6: Writing an outbound slot that is still full replaces the word. The full flag stays set and the inbound interrupt does not drop in between.
- R7: Writing 1 to ring-request bit 19−n sets the far side's doorbell-pending n on the next cycle. Ring-request bits always read 0.
- R8: Writing 1 to a doorbell-pending bit in status clears it, and writing 0 leaves it set. When a clear and a new ring for the same bit meet in one cycle, the bit stays set.
- R9: irq_tx = OR over n of (outbound-empty n AND outbound-enable n). irq_rx = OR over n of (inbound-full n AND inbound-enable n). irq_gp = OR over n of (doorbell-pending n AND doorbell-enable n).
- R10: A control write with bit 5 set returns both sides to the R1 state at once. Reset-busy then reads 1 for RST_CYCLES cycles and returns to 0. Writes made while reset-busy is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (consumes inbound words) |
| a_addr | input | AW | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the cycle of the address |
| a_irq_tx | output | 1 | Side A outbound interrupt |
| a_irq_rx | output | 1 | Side A inbound interrupt |
| a_irq_gp | output | 1 | Side A doorbell interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | AW | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq_tx | output | 1 | Side B outbound interrupt |
| b_irq_rx | output | 1 | Side B inbound interrupt |
| b_irq_gp | output | 1 | Side B doorbell interrupt |

## Verification
The bench targets an overwrite of a slot that is still full. A design that toggles the flag there would drop the inbound interrupt or lose the second word. A doorbell clear and a fresh ring that land in the same cycle are driven together, which exposes a design that lets the clear win and loses a doorbell. Reset requests are checked for the exact busy length and for writes arriving during busy, so a short busy window or a write that leaks through shows up as a wrong flag. Random traffic compares every read and every interrupt with a bench model, which catches a slot whose bit order in status or control is not reversed.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;
  localparam int NUM_CH    = 4;
  localparam int REG_W     = 32;
  localparam int WORD_TX0  = 0;
  localparam int WORD_RX0  = 4;
  localparam int WORD_STAT = 8;
  localparam int WORD_CTRL = 9;
  localparam int GP_LSB    = 28;
  localparam int RF_LSB    = 24;
  localparam int TE_LSB    = 20;
  localparam int RING_LSB  = 16;
  localparam int RST_REQ_BIT  = 5;
  localparam int RST_BUSY_BIT = 7;

  typedef struct packed {
    logic [NUM_CH-1:0] gp_en;
    logic [NUM_CH-1:0] rx_en;
    logic [NUM_CH-1:0] tx_en;
  } ctrl_t;
endpackage

// File: rtl/ipcmb_reset_ctl.sv
module ipcmb_reset_ctl #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic srst_n,
  output logic busy,
  output logic clr
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic sync1_q, sync2_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end
  assign srst_n = sync2_q;

  assign req  = req_a | req_b;
  assign busy = (cnt_q != '0);
  assign clr  = req | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (req)       cnt_d = CNT_W'(RST_CYCLES);
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!srst_n)
    req |=> busy);
  assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && !req && cnt_q == CNT_W'(1)) |=> !busy);
endmodule

// File: rtl/ipcmb_lane.sv
module ipcmb_lane
  import ipcmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             rd,
  output logic [REG_W-1:0] data,
  output logic             full
);
  logic [REG_W-1:0] data_q, data_d;
  logic full_q, full_d, data_en;

  assign data_en = clr | wr;

  always_comb begin
    data_d = clr ? '0 : wdata;
    if (clr)     full_d = 1'b0;
    else if (wr) full_d = 1'b1;
    else if (rd) full_d = 1'b0;
    else         full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (data_en) data_q <= data_d;
      full_q <= full_d;
    end
  end

  assign data = data_q;
  assign full = full_q;

  assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (full && data == $past(wdata)));
  assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !clr) |=> !full);
  assert_overwrite_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !clr) |=> full);
endmodule

// File: rtl/ipcmb_side.sv
module ipcmb_side
  import ipcmb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          busy,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [AW-1:0]                 addr,
  input  logic [REG_W-1:0]              wdata,
  output logic [REG_W-1:0]              rdata,
  input  logic [NUM_CH-1:0]             tx_full,
  input  logic [NUM_CH-1:0][REG_W-1:0]  tx_data,
  input  logic [NUM_CH-1:0]             rx_full,
  input  logic [NUM_CH-1:0][REG_W-1:0]  rx_data,
  input  logic [NUM_CH-1:0]             far_ring,
  output logic [NUM_CH-1:0]             tx_wr,
  output logic [NUM_CH-1:0]             rx_rd,
  output logic [NUM_CH-1:0]             ring,
  output logic                          rst_req,
  output logic                          irq_tx,
  output logic                          irq_rx,
  output logic                          irq_gp
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;
  logic stat_wr, ctrl_wr;
  ctrl_t ctrl_q, ctrl_d;
  logic [NUM_CH-1:0] pend_q, pend_d, pend_clr;
  logic [NUM_CH-1:0] te_f, rf_f;
  logic [REG_W-1:0] stat_val, ctrl_val;

  assign word    = addr[AW-1:2];
  assign stat_wr = wr_en && (word == WW'(WORD_STAT));
  assign ctrl_wr = wr_en && (word == WW'(WORD_CTRL));
  assign rst_req = ctrl_wr && wdata[RST_REQ_BIT];

  // Per-channel strobes; field bit (NUM_CH-1-i) belongs to channel i
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign tx_wr[i] = wr_en && (word == WW'(WORD_TX0 + i));
    assign rx_rd[i] = rd_en && (word == WW'(WORD_RX0 + i));
    assign te_f[NUM_CH-1-i] = ~tx_full[i];
    assign rf_f[NUM_CH-1-i] = rx_full[i];
  end

  assign ring     = ctrl_wr ? wdata[RING_LSB +: NUM_CH] : '0;
  assign pend_clr = stat_wr ? wdata[GP_LSB +: NUM_CH] : '0;

  always_comb begin
    ctrl_d = ctrl_q;
    if (clr) ctrl_d = '0;
    else if (ctrl_wr) begin
      ctrl_d.gp_en = wdata[GP_LSB +: NUM_CH];
      ctrl_d.rx_en = wdata[RF_LSB +: NUM_CH];
      ctrl_d.tx_en = wdata[TE_LSB +: NUM_CH];
    end
    // a ring from the far side wins over a same-cycle clear
    pend_d = clr ? '0 : ((pend_q & ~pend_clr) | far_ring);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    stat_val = '0;
    stat_val[GP_LSB +: NUM_CH] = pend_q;
    stat_val[RF_LSB +: NUM_CH] = rf_f;
    stat_val[TE_LSB +: NUM_CH] = te_f;
    stat_val[RST_BUSY_BIT]     = busy;
    ctrl_val = '0;
    ctrl_val[GP_LSB +: NUM_CH] = ctrl_q.gp_en;
    ctrl_val[RF_LSB +: NUM_CH] = ctrl_q.rx_en;
    ctrl_val[TE_LSB +: NUM_CH] = ctrl_q.tx_en;
  end

  always_comb begin
    rdata = '0;
    if (word < WW'(WORD_RX0))            rdata = tx_data[word[1:0]];
    else if (word < WW'(WORD_STAT))      rdata = rx_data[word[1:0]];
    else if (word == WW'(WORD_STAT))     rdata = stat_val;
    else if (word == WW'(WORD_CTRL))     rdata = ctrl_val;
  end

  assign irq_tx = |(te_f & ctrl_q.tx_en);
  assign irq_rx = |(rf_f & ctrl_q.rx_en);
  assign irq_gp = |(pend_q & ctrl_q.gp_en);

  assert_ring_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|far_ring && !clr) |=> ((pend_q & $past(far_ring)) == $past(far_ring)));
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_clr && !clr) |=> ((pend_q & $past(pend_clr) & ~$past(far_ring)) == '0));
  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctrl_q == '0 && pend_q == '0 && !irq_gp));
  assert_ring_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word == WW'(WORD_CTRL)) |-> (rdata[RING_LSB +: NUM_CH] == '0));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipcmb_pkg::*;
#(
  parameter int AW         = 6,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_wr_en,
  input  logic             a_rd_en,
  input  logic [AW-1:0]    a_addr,
  input  logic [REG_W-1:0] a_wdata,
  output logic [REG_W-1:0] a_rdata,
  output logic             a_irq_tx,
  output logic             a_irq_rx,
  output logic             a_irq_gp,
  input  logic             b_wr_en,
  input  logic             b_rd_en,
  input  logic [AW-1:0]    b_addr,
  input  logic [REG_W-1:0] b_wdata,
  output logic [REG_W-1:0] b_rdata,
  output logic             b_irq_tx,
  output logic             b_irq_rx,
  output logic             b_irq_gp
);
  logic srst_n, busy, clr, a_rst_req, b_rst_req;
  logic [NUM_CH-1:0] a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd, a_ring, b_ring;
  logic [NUM_CH-1:0] ab_full, ba_full;
  logic [NUM_CH-1:0][REG_W-1:0] ab_data, ba_data;

  ipcmb_reset_ctl #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .req_a(a_rst_req), .req_b(b_rst_req),
    .srst_n(srst_n), .busy(busy), .clr(clr));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    ipcmb_lane u_ab (
      .clk(clk), .rst_n(srst_n), .clr(clr), .wr(a_tx_wr[i]), .wdata(a_wdata),
      .rd(b_rx_rd[i]), .data(ab_data[i]), .full(ab_full[i]));
    ipcmb_lane u_ba (
      .clk(clk), .rst_n(srst_n), .clr(clr), .wr(b_tx_wr[i]), .wdata(b_wdata),
      .rd(a_rx_rd[i]), .data(ba_data[i]), .full(ba_full[i]));
  end

  ipcmb_side #(.AW(AW)) u_side_a (
    .clk(clk), .rst_n(srst_n), .clr(clr), .busy(busy),
    .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata),
    .tx_full(ab_full), .tx_data(ab_data), .rx_full(ba_full), .rx_data(ba_data),
    .far_ring(b_ring), .tx_wr(a_tx_wr), .rx_rd(a_rx_rd), .ring(a_ring),
    .rst_req(a_rst_req), .irq_tx(a_irq_tx), .irq_rx(a_irq_rx), .irq_gp(a_irq_gp));

  ipcmb_side #(.AW(AW)) u_side_b (
    .clk(clk), .rst_n(srst_n), .clr(clr), .busy(busy),
    .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata),
    .tx_full(ba_full), .tx_data(ba_data), .rx_full(ab_full), .rx_data(ab_data),
    .far_ring(a_ring), .tx_wr(b_tx_wr), .rx_rd(b_rx_rd), .ring(b_ring),
    .rst_req(b_rst_req), .irq_tx(b_irq_tx), .irq_rx(b_irq_rx), .irq_gp(b_irq_gp));
endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  localparam int AW = 6;
  localparam int RSTC = 4;

  logic clk, rst_n;
  logic wr_en [2], rd_en [2];
  logic [AW-1:0] addr [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic irq_tx [2], irq_rx [2], irq_gp [2];

  int checks = 0, errors = 0;

  // bench model; gp/en fields kept in register order (bit 3-n = channel n)
  bit [31:0] m_data [2][4];
  bit        m_full [2][4];
  bit [3:0]  m_gp [2], m_gie [2], m_rie [2], m_tie [2];

  initial clk = 0;
  always #4 clk = ~clk;

  ipc_mailbox #(.AW(AW), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(wr_en[0]), .a_rd_en(rd_en[0]), .a_addr(addr[0]), .a_wdata(wdata[0]),
    .a_rdata(rdata[0]), .a_irq_tx(irq_tx[0]), .a_irq_rx(irq_rx[0]), .a_irq_gp(irq_gp[0]),
    .b_wr_en(wr_en[1]), .b_rd_en(rd_en[1]), .b_addr(addr[1]), .b_wdata(wdata[1]),
    .b_rdata(rdata[1]), .b_irq_tx(irq_tx[1]), .b_irq_rx(irq_rx[1]), .b_irq_gp(irq_gp[1]));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) begin m_data[s][n] = 0; m_full[s][n] = 0; end
      m_gp[s] = 0; m_gie[s] = 0; m_rie[s] = 0; m_tie[s] = 0;
    end
  endfunction

  function automatic bit [3:0] te_f(int s);
    bit [3:0] f;
    for (int n = 0; n < 4; n++) f[3-n] = ~m_full[s][n];
    return f;
  endfunction

  function automatic bit [3:0] rf_f(int s);
    bit [3:0] f;
    for (int n = 0; n < 4; n++) f[3-n] = m_full[1-s][n];
    return f;
  endfunction

  function automatic bit [31:0] exp_read(int s, bit [AW-1:0] a, bit busy);
    bit [3:0] w = a[5:2];
    if (w < 4) return m_data[s][w];
    if (w < 8) return m_data[1-s][w-4];
    if (w == 8) return {m_gp[s], rf_f(s), te_f(s), 12'h0, busy, 7'h0};
    if (w == 9) return {m_gie[s], m_rie[s], m_tie[s], 20'h0};
    return 0;
  endfunction

  function automatic void model_apply(int s, bit w_, bit r_, bit [AW-1:0] a, bit [31:0] d);
    bit [3:0] w = a[5:2];
    if (w_) begin
      if (w < 4) begin m_data[s][w] = d; m_full[s][w] = 1; end
      else if (w == 8) m_gp[s] &= ~d[31:28];
      else if (w == 9) begin
        m_gie[s] = d[31:28]; m_rie[s] = d[27:24]; m_tie[s] = d[23:20];
        m_gp[1-s] |= d[19:16];
      end
    end
    if (r_ && w >= 4 && w < 8) m_full[1-s][w-4] = 0;
  endfunction

  task automatic chk_irqs(int s);
    chk("R9 irq_tx", 32'(irq_tx[s]), 32'(|(te_f(s) & m_tie[s])));
    chk("R9 irq_rx", 32'(irq_rx[s]), 32'(|(rf_f(s) & m_rie[s])));
    chk("R9 irq_gp", 32'(irq_gp[s]), 32'(|(m_gp[s] & m_gie[s])));
  endtask

  // one bus access on side s; read data checked before the edge
  task automatic access(int s, bit w_, bit r_, bit [AW-1:0] a, bit [31:0] d, string req);
    @(negedge clk);
    wr_en[s] = w_; rd_en[s] = r_; addr[s] = a; wdata[s] = d;
    #2;
    if (r_) chk(req, rdata[s], exp_read(s, a, 1'b0));
    chk_irqs(s);
    @(posedge clk); #1;
    wr_en[s] = 0; rd_en[s] = 0;
    model_apply(s, w_, r_, a, d);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < 2; s++) begin
      wr_en[s] = 0; rd_en[s] = 0; addr[s] = 0; wdata[s] = 0;
    end
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    access(0, 0, 1, 6'h20, 0, "R1 status A");
    access(1, 0, 1, 6'h20, 0, "R1 status B");
    chk("R1 status value", exp_read(0, 6'h20, 0), 32'h00F0_0000);
    access(1, 0, 1, 6'h24, 0, "R1 control B");

    // R4/R5: A slot 2 -> B; flags at bits 21 / 25
    access(0, 1, 0, 6'h08, 32'hCAFE_0002, "R4 write");
    access(0, 0, 1, 6'h20, 0, "R4 A empty cleared");
    access(1, 0, 1, 6'h20, 0, "R4 B full set");
    access(1, 0, 1, 6'h18, 0, "R4/R5 B reads word");
    access(0, 0, 1, 6'h20, 0, "R5 A empty restored");
    access(1, 0, 1, 6'h18, 0, "R5 empty read keeps flags");
    access(1, 0, 1, 6'h20, 0, "R5 B status after");

    // R6: overwrite while full with rx interrupt enabled on B
    access(1, 1, 0, 6'h24, 32'h0F00_0000, "R6 enable");
    access(0, 1, 0, 6'h00, 32'h1111_1111, "R6 first");
    access(0, 1, 0, 6'h00, 32'h2222_2222, "R6 overwrite");
    chk("R6 irq held", 32'(irq_rx[1]), 32'd1);
    access(1, 0, 1, 6'h10, 0, "R6 second word");
    access(1, 0, 1, 6'h20, 0, "R6 flag cleared");

    // R7/R8: doorbells
    access(1, 1, 0, 6'h24, 32'h000A_0000, "R7 ring ch0,ch2");
    access(0, 0, 1, 6'h20, 0, "R7 pending on A");
    access(1, 0, 1, 6'h24, 0, "R7 ring bits read 0");
    access(0, 1, 0, 6'h20, 32'h0000_0000, "R8 write zero");
    access(0, 0, 1, 6'h20, 0, "R8 zero keeps");
    access(0, 1, 0, 6'h20, 32'h2000_0000, "R8 clear ch2");
    access(0, 0, 1, 6'h20, 0, "R8 ch2 cleared");
    // same-cycle clear by A and ring by B on channel 0
    @(negedge clk);
    wr_en[0] = 1; addr[0] = 6'h20; wdata[0] = 32'h8000_0000;
    wr_en[1] = 1; addr[1] = 6'h24; wdata[1] = 32'h0008_0000;
    @(posedge clk); #1;
    wr_en[0] = 0; wr_en[1] = 0;
    m_gie[1] = 0; m_rie[1] = 0; m_tie[1] = 0;
    m_gp[0] = 4'b1000;
    access(0, 0, 1, 6'h20, 0, "R8 ring wins over clear");

    // R2: decode of unmapped and inbound writes
    access(0, 1, 0, 6'h14, 32'hDEAD_BEEF, "R2 write inbound ignored");
    access(0, 0, 1, 6'h14, 0, "R2 inbound unchanged");
    access(0, 0, 1, 6'h0C, 0, "R2 outbound readback");
    access(0, 1, 0, 6'h2C, 32'hFFFF_FFFF, "R2 unmapped write");
    access(0, 0, 1, 6'h2C, 0, "R2 unmapped reads 0");
    access(0, 0, 1, 6'h20, 0, "R2 status intact");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(0, 1);
      int k = $urandom_range(0, 8);
      int n = $urandom_range(0, 3);
      bit [31:0] d = $urandom;
      case (k)
        0, 1: access(s, 1, 0, 6'(n*4), d, "R4 rand tx");
        2, 3: access(s, 0, 1, 6'(16 + n*4), 0, "R5 rand rx");
        4:    access(s, 0, 1, 6'h20, 0, "R3 rand status");
        5:    access(s, 1, 0, 6'h20, d, "R8 rand clear");
        6:    access(s, 1, 0, 6'h24, d & 32'hFFFF_FFDF, "R7 rand ctrl");
        7:    access(s, 0, 1, 6'h24, 0, "R3 rand ctrl");
        default: access(s, 0, 1, 6'(n*4), 0, "R2 rand tx readback");
      endcase
    end

    // R10: soft reset from B, busy window and ignored writes
    access(0, 1, 0, 6'h24, 32'hFFF0_0000, "R10 setup");
    access(0, 1, 0, 6'h04, 32'h1234_5678, "R10 setup word");
    @(negedge clk);
    wr_en[1] = 1; addr[1] = 6'h24; wdata[1] = 32'h0000_0020;
    @(posedge clk); #1;
    wr_en[1] = 0;
    model_reset();
    for (int c = 0; c < RSTC; c++) begin
      @(negedge clk);
      addr[0] = 6'h20; addr[1] = 6'h20;
      wr_en[1] = (c == 1); if (c == 1) begin addr[1] = 6'h00; wdata[1] = 32'h5555_5555; end
      #2;
      chk("R10 busy A", rdata[0], exp_read(0, 6'h20, 1'b1));
      @(posedge clk); #1;
      wr_en[1] = 0;
    end
    access(0, 0, 1, 6'h20, 0, "R10 busy over, flags reset");
    access(1, 0, 1, 6'h24, 0, "R10 control cleared");
    access(0, 0, 1, 6'h10, 0, "R10 data cleared, write in busy ignored");
    access(1, 0, 1, 6'h20, 0, "R10 B status");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule